// File: doc/BRIEF.md
# Keyed Down-Counting Watchdog with Early Warning

This block guards a processor against software that has stopped making progress. A free-running prescaler divides the system clock into a slow tick. An 8-bit counter counts those ticks down from a start value. Software reloads the counter before it runs out. When the count reaches 1 the block sends a one-cycle non-maskable interrupt request, which gives the processor one tick period to record its state. When the count reaches 0 the block raises a reset request, and that request stays high until the block's own reset clears it. With a 17-bit prescaler and a 100 MHz clock, one tick lasts 131072 cycles, so the count falls at about 763 Hz.

Software controls the block with a single write. The write carries a start value, a command bit and a 7-bit key. A write is accepted only if its key is the bitwise complement of the key from the last accepted write. A stray or runaway write therefore cannot stop or feed the watchdog. A write with the wrong key has no effect. A start command issued while the watchdog is running reloads the counter, so the same operation both starts and feeds it.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, `countOut` is 0, `runningOut` is 0, `nmiOut` is 0 and `sysResetOut` is 0. The stored key is `KEY_INIT` (0), so the first key that is accepted is 7'h7F.
- R2: A write (`wrEn` high for one cycle) is accepted only if `wrKey` equals the bitwise complement of the stored key. An accepted write stores its own `wrKey` as the new stored key.
- R3: A write whose key does not match changes nothing. The count, the run state and the stored key all keep their values, and a running count keeps descending on its original schedule.
- R4: An accepted write with `wrStart` = 1 loads `wrCount`, sets the block running and clears the prescaler. The loaded count is visible after that clock edge. A start issued while running is a reload.
- R5: An accepted write with `wrStart` = 0 stops the count and holds its present value. The decrement that would fall on that edge is skipped.
- R6: While running, the count falls by exactly one every 2^`PRE_W` clock cycles. The first decrement comes 2^`PRE_W` edges after the accepting edge. The count never goes below 0.
- R7: `nmiOut` is a single-cycle pulse. It is issued on the edge where the count drops from 2 to 1, or on the accepting edge of a start that loads 1.
- R8: On a tick with the count at 1 or 0, `sysResetOut` goes high, the count reaches 0 and the block stops. `sysResetOut` then stays high, and every write is ignored, until `rstN` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control write strobe |
| wrStart | input | 1 | Command: 1 start or reload, 0 stop |
| wrCount | input | CNT_W | Start value for the counter |
| wrKey | input | KEY_W | Key presented with the write |
| nmiOut | output | 1 | Early-warning interrupt pulse |
| sysResetOut | output | 1 | Sticky system reset request |
| countOut | output | CNT_W | Current count |
| runningOut | output | 1 | Counter is running |

## Verification
A stored key that is wrong shows up on the next write: a correct write is then refused, so `countOut` is not reloaded one cycle after the edge. A prescaler that is off by one moves the first decrement, and the error is visible on `countOut` within a single tick period. An NMI or reset on the wrong count appears on `nmiOut` or `sysResetOut` one tick early or late. A reset request that is not held drops within one cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes sent from the control unit to the datapath.
  typedef struct packed {
    logic load;    // load the start value into the counter
    logic dec;     // count down by one on this edge
    logic preClr;  // clear the prescaler
    logic preRun;  // advance the prescaler
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             tick
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] preQ;

  // Prescaler: advances only while running, and is cleared by an accepted start.
  always_ff @(posedge clk) begin
    if (!rstN)            preQ <= '0;
    else if (strb.preClr) preQ <= '0;
    else if (strb.preRun) preQ <= preQ + 1'b1;
  end

  assign tick = strb.preRun && (preQ == PRE_LAST);

  // Counter: a load takes priority over a decrement; the count stops at zero.
  always_ff @(posedge clk) begin
    if (!rstN)                          count <= '0;
    else if (strb.load)                 count <= loadVal;
    else if (strb.dec && (count != '0)) count <= count - 1'b1;
  end
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int              CNT_W    = 8,
  parameter int              KEY_W    = 7,
  parameter logic [KEY_W-1:0] KEY_INIT = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrStart,
  input  logic [KEY_W-1:0] wrKey,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] count,
  input  logic             tick,
  output wdtStrobe_t       strb,
  output logic             running,
  output logic             nmi,
  output logic             bite,
  output logic [KEY_W-1:0] keyQ
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

  logic accept, startAcc, stopAcc, tickLive, fire;

  assign accept   = wrEn && !bite && (wrKey == ~keyQ);
  assign startAcc = accept && wrStart;
  assign stopAcc  = accept && !wrStart;
  assign tickLive = tick && !accept && !bite;
  assign fire     = tickLive && (count <= CNT_ONE);

  always_comb begin
    strb.load   = startAcc;
    strb.preClr = startAcc;
    strb.preRun = running;
    strb.dec    = tickLive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) keyQ <= KEY_INIT;
    else if (accept) keyQ <= wrKey;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                running <= 1'b0;
    else if (bite || fire)    running <= 1'b0;
    else if (startAcc)        running <= 1'b1;
    else if (stopAcc)         running <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         nmi <= 1'b0;
    else if (startAcc) nmi <= (loadVal == CNT_ONE);
    else               nmi <= tickLive && (count == CNT_TWO);
  end

  always_ff @(posedge clk) begin
    if (!rstN) bite <= 1'b0;
    else       bite <= bite || fire;
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int               CNT_W    = 8,
  parameter int               KEY_W    = 7,
  parameter int               PRE_W    = 17,
  parameter logic [KEY_W-1:0] KEY_INIT = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrStart,
  input  logic [CNT_W-1:0] wrCount,
  input  logic [KEY_W-1:0] wrKey,
  output logic             nmiOut,
  output logic             sysResetOut,
  output logic [CNT_W-1:0] countOut,
  output logic             runningOut
);
  wdtStrobe_t       strb;
  logic [CNT_W-1:0] count;
  logic [KEY_W-1:0] keyQ;
  logic             tick;

  wdt_control #(.CNT_W(CNT_W), .KEY_W(KEY_W), .KEY_INIT(KEY_INIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrStart(wrStart), .wrKey(wrKey),
    .loadVal(wrCount), .count(count), .tick(tick), .strb(strb),
    .running(runningOut), .nmi(nmiOut), .bite(sysResetOut), .keyQ(keyQ)
  );

  wdt_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(wrCount),
    .count(count), .tick(tick)
  );

  assign countOut = count;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CNT_W = 8,
  parameter int KEY_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [KEY_W-1:0] wrKey,
  input logic [KEY_W-1:0] keyQ,
  input logic             tick,
  input logic             nmiOut,
  input logic             sysResetOut,
  input logic [CNT_W-1:0] countOut,
  input logic             runningOut
);
  // R3: a write with a wrong key leaves the state alone (no tick in that cycle)
  a_r3_bad_key_inert: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrKey != ~keyQ) && !tick)
      |=> ($stable(countOut) && $stable(runningOut) && $stable(keyQ)));

  // R2: an accepted write stores its own key
  a_r2_key_stored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrKey == ~keyQ) && !sysResetOut) |=> (keyQ == $past(wrKey)));

  // R5: while stopped and not written, the count holds
  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!runningOut && !wrEn) |=> $stable(countOut));

  // R6: a tick with no write lowers a count above one by exactly one
  a_r6_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !wrEn && !sysResetOut && (countOut > CNT_W'(1)))
      |=> (countOut == CNT_W'($past(countOut) - 1'b1)));

  // R7: the warning is a single-cycle pulse
  a_r7_nmi_pulse: assert property (@(posedge clk) disable iff (!rstN)
    nmiOut |=> !nmiOut);

  // R8: the reset request is sticky and the block is halted at zero
  a_r8_reset_sticky: assert property (@(posedge clk) disable iff (!rstN)
    sysResetOut |=> (sysResetOut && !runningOut && (countOut == '0)));
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W), .KEY_W(KEY_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKey(wrKey), .keyQ(keyQ),
  .tick(tick), .nmiOut(nmiOut), .sysResetOut(sysResetOut),
  .countOut(countOut), .runningOut(runningOut)
);

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;
  localparam int PRE_W = 3;
  localparam int T     = 1 << PRE_W;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrStart = 1'b0;
  logic [7:0] wrCount = '0;
  logic [6:0] wrKey = '0;
  logic       nmiOut, sysResetOut, runningOut;
  logic [7:0] countOut;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // bench model of the block
  logic [6:0] keyExp;
  bit  runE;
  int  expN, m, held;

  always #2 clk = ~clk;

  wdt_keyed #(.PRE_W(PRE_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrStart(wrStart), .wrCount(wrCount),
    .wrKey(wrKey), .nmiOut(nmiOut), .sysResetOut(sysResetOut),
    .countOut(countOut), .runningOut(runningOut)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired: actual=%0d expected<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int expCount();
    int v;
    if (!runE) return held;
    v = m / T;
    return (v >= expN) ? 0 : expN - v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); m++;
  endtask

  // Called at a negedge; drives a one-cycle write and returns at the next negedge.
  task automatic doWrite(input int n, input bit st, input logic [6:0] k);
    bit good;
    good = (k == ~keyExp) && !sysResetOut;
    wrEn = 1'b1; wrStart = st; wrCount = 8'(n); wrKey = k;
    if (good) begin
      keyExp = k;
      if (st) begin runE = 1; expN = n; m = -1; end
      else begin held = expCount(); runE = 0; end
    end
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    m++;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
    keyExp = 7'h00; runE = 0; held = 0; expN = 0; m = 0;
  endtask

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    @(negedge clk);
    doReset();

    // R1: reset state
    chk("R1 count", countOut, 0);
    chk("R1 running", runningOut, 0);
    chk("R1 nmi", nmiOut, 0);
    chk("R1 sysReset", sysResetOut, 0);

    // R3 / R2: a key of 0 is not the complement of the initial key
    doWrite(9, 1, 7'h00);
    chk("R3 bad first key running", runningOut, 0);
    chk("R3 bad first key count", countOut, 0);

    // R2 / R4: the first valid key is 7F
    doWrite(4, 1, 7'h7F);
    chk("R4 start count", countOut, 4);
    chk("R4 start running", runningOut, 1);
    repeat (7) step();
    chk("R6 before first tick", countOut, 4);
    step();
    chk("R6 first decrement", countOut, 3);

    // R3: wrong key while running; the schedule is unchanged
    doWrite(100, 1, 7'h2A);
    chk("R3 running bad key count", countOut, expCount());
    chk("R3 running bad key run", runningOut, 1);

    // R4: kick with the complemented key
    doWrite(6, 1, 7'h00);
    chk("R4 kick reload", countOut, 6);

    // R7: NMI exactly at the edge that brings the count to 1
    while (m < 44) begin
      chk("R7 nmi timing", nmiOut, (m == 40) ? 1 : 0);
      step();
    end
    chk("R6 count at 44", countOut, 1);

    // R5: stop holds the count
    doWrite(0, 0, 7'h7F);
    chk("R5 stopped run", runningOut, 0);
    repeat (20) step();
    chk("R5 stopped count", countOut, 1);
    chk("R5 no reset while stopped", sysResetOut, 0);

    // R7 / R8: load 1, NMI at once, reset one tick later
    doWrite(1, 1, 7'h00);
    chk("R7 nmi on load of 1", nmiOut, 1);
    repeat (7) step();
    chk("R8 no reset yet", sysResetOut, 0);
    step();
    chk("R8 reset asserted", sysResetOut, 1);
    chk("R8 count zero", countOut, 0);
    chk("R8 halted", runningOut, 0);
    doWrite(50, 1, 7'h7F);
    chk("R8 write ignored count", countOut, 0);
    repeat (10) step();
    chk("R8 reset sticky", sysResetOut, 1);

    // Random phase
    doReset();
    chk("R1 reset clears bite", sysResetOut, 0);
    for (int it = 0; it < 60; it++) begin
      int op;
      op = int'($urandom_range(2, 0));
      if (op == 1 && runE && (m >= (expN - 1) * T - 2)) op = 0;
      if (op == 0) begin
        int n, s;
        n = int'($urandom_range(30, 3));
        doWrite(n, 1, ~keyExp);
        chk("R4 random load", countOut, n);
        s = int'($urandom_range((n - 1) * T - 3, 0));
        repeat (s) step();
        chk("R6 random count", countOut, expCount());
      end else if (op == 1) begin
        logic [6:0] k;
        k = 7'($urandom());
        if (k == ~keyExp) k = k ^ 7'h01;
        doWrite(int'($urandom_range(255, 0)), 1'($urandom()), k);
        chk("R3 random bad key count", countOut, expCount());
        chk("R3 random bad key run", runningOut, runE ? 1 : 0);
      end else begin
        doWrite(0, 0, ~keyExp);
        chk("R5 random stop run", runningOut, 0);
        repeat (5) step();
        chk("R5 random stop hold", countOut, expCount());
      end
      chk("R8 no random bite", sysResetOut, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule